// File: doc/BRIEF.md
# Serial Configuration EEPROM Target

This block answers on a two-wire I2C bus as a 256-byte configuration memory of the kind that a memory module carries to describe itself. A host writes a word address, then reads one byte or a run of bytes. It can also read from wherever the internal pointer was left. Byte writes land directly in the array, one byte at a time. The array is preloaded from a parameter and returns to that content on reset.

The array has two halves. The lower half (0 to 127) holds the manufacturer's description. A write-protect input locks that half. The upper half (128 to 255) is free for the user and always writable. A flag output reports, every cycle, whether byte 63 matches the 8-bit sum of bytes 0 to 62. A host can use it to spot a corrupted description without reading the whole table.

The bus pins are open-drain. The block only ever pulls SDA low and never drives SCL. It does not stretch the clock and does not arbitrate against other controllers. SCL and SDA are sampled through two-flop synchronizers, so the system clock must run several times faster than the bus clock.

Top module: `spd_i2c_target`

## Requirements
- R1: The block acknowledges only the 7-bit target address formed as 1010 in the top four bits followed by strap[2:0]. The bit after the address is 1 for a read and 0 for a write. A byte with any other address gets no acknowledge, and the block stays off the bus until the next START.
- R2: A write transfer carrying one word-address byte, followed by a repeated START and a read, returns the byte stored at that address.
- R3: During a read, each byte the host acknowledges is followed by the byte at the next address. The address after 255 is 0.
- R4: A read that is not preceded by a word-address write starts at the current pointer. The pointer always points one past the last byte read or accepted for writing, or at the word address last written.
- R5: Writes to addresses 128 to 255 are acknowledged and stored regardless of wp. Several data bytes in one transfer go to successive addresses.
- R6: While wp is 1, a data byte aimed at an address from 0 to 127 is not acknowledged and leaves memory unchanged.
- R7: While wp is 0, data bytes aimed at addresses 0 to 127 are acknowledged and stored.
- R8: checksum_ok is 1 exactly when the low 8 bits of the sum of bytes 0 to 62 equal byte 63. It follows every accepted write.
- R9: The default preload holds 0x80 at byte 0 (bytes in use), 0x04 at byte 2 (memory type), 0xE1 at byte 63 (a valid checksum) and 0xFF at bytes 64 to 255.
- R10: A STOP in the middle of a byte ends the transfer without a write. A START in the middle of a byte throws away the partial byte and begins a new address phase.
- R11: sda_pull only turns on while SCL is low, so the block never makes a START or STOP of its own.
- R12: After reset, sda_pull is 0, the pointer is 0 and the memory holds the preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| strap | input | 3 | Low three bits of the target address |
| wp | input | 1 | 1 locks the manufacturer half against writes |
| checksum_ok | output | 1 | Stored checksum at byte 63 matches bytes 0 to 62 |

## Verification
The bench builds the block with its default parameters: the 1010 address prefix, an 8-bit word address and the default preload. Because that preload carries a valid checksum and a known pattern in both halves, every read has an expected value the bench can write down. Wrap-around from 255 to 0 can be reached through the real 8-bit pointer. Corrupting byte 10 and then repairing byte 63 drives the checksum flag both ways.

// File: rtl/spd_i2c_target.sv
module spd_i2c_target #(
  parameter logic [3:0] DEV_ID  = 4'b1010,
  parameter int         AW      = 8,
  parameter int         CSUM_AT = 63,
  parameter logic [8*(2**AW)-1:0] INIT =
    {{192{8'hFF}}, 8'hE1, {56{8'h00}}, 8'h40, 8'h01, 8'h08, 8'h0C, 8'h04, 8'h08, 8'h80}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       checksum_ok
);
  localparam int DEPTH = 2**AW;

  typedef enum logic [2:0] {IDLE, DEVB, WADR, WDAT, ACKP, RDAT, RACK} st_t;

  st_t          state, nxt;
  logic [2:0]   scl_q, sda_q;
  logic [3:0]   cnt;
  logic [7:0]   sh;
  logic [AW-1:0] ptr;
  logic         mack;
  logic [7:0]   mem [DEPTH];
  logic [7:0]   sum;

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire byte_end = scl_fall && cnt == 4'd8;
  wire wr_ok    = ptr[AW-1] | ~wp;
  wire mem_we   = !start_c && !stop_c && state == WDAT && byte_end && wr_ok;
  wire [2:0] bsel = 3'(4'd7 - cnt);

  always_comb begin
    sum = 8'd0;
    for (int i = 0; i < CSUM_AT; i++) sum = sum + mem[i];
  end
  assign checksum_ok = (sum == mem[CSUM_AT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT[8*i +: 8];
    end else if (mem_we) begin
      mem[ptr] <= sh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; nxt <= IDLE; cnt <= '0; sh <= '0;
      ptr <= '0; sda_pull <= 1'b0; mack <= 1'b0;
    end else if (start_c) begin
      state <= DEVB; cnt <= '0; sda_pull <= 1'b0;
    end else if (stop_c) begin
      state <= IDLE; sda_pull <= 1'b0;
    end else begin
      case (state)
        DEVB, WADR, WDAT: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt   <= '0;
            state <= ACKP;
            case (state)
              DEVB: if (sh[7:1] == {DEV_ID, strap}) begin
                      sda_pull <= 1'b1;
                      nxt      <= sh[0] ? RDAT : WADR;
                    end else begin
                      state <= IDLE;
                    end
              WADR: begin
                      sda_pull <= 1'b1;
                      ptr      <= AW'(sh);
                      nxt      <= WDAT;
                    end
              default: if (wr_ok) begin
                      sda_pull <= 1'b1;
                      ptr      <= ptr + 1'b1;
                      nxt      <= WDAT;
                    end else begin
                      nxt <= IDLE;
                    end
            endcase
          end
        end
        ACKP: if (scl_fall) begin
          state    <= nxt;
          cnt      <= '0;
          sda_pull <= (nxt == RDAT) ? ~mem[ptr][7] : 1'b0;
        end
        RDAT: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull <= 1'b0;
              ptr      <= ptr + 1'b1;
              state    <= RACK;
            end else begin
              sda_pull <= ~mem[ptr][bsel];
            end
          end
        end
        RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              state    <= RDAT;
              cnt      <= '0;
              sda_pull <= ~mem[ptr][7];
            end else begin
              state <= IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module spd_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic pull,
  input logic mem_we,
  input logic wp,
  input logic upper,
  input logic csum,
  input logic idle
);
  p_pull_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !scl_s);
  p_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp) |-> upper);
  p_csum_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mem_we) |-> $stable(csum));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !pull);
endmodule

bind spd_i2c_target spd_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_q[1]), .pull(sda_pull),
  .mem_we(mem_we), .wp(wp), .upper(ptr[AW-1]), .csum(checksum_ok),
  .idle(state == IDLE)
);

// File: tb/spd_i2c_target_test.sv
module spd_i2c_target_test;
  localparam int T = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic [2:0] strap = 3'b000;
  logic wp = 1'b1;
  logic sda_pull, checksum_ok;
  wire  sda_line = ~(m_sda_low | sda_pull);

  int nchk = 0, nfail = 0;
  bit bad_pull = 1'b0;
  logic prev_pull = 1'b0;

  always #5 clk = ~clk;

  spd_i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .strap(strap), .wp(wp), .checksum_ok(checksum_ok)
  );

  always @(negedge clk) begin
    if (rst_n && sda_pull && !prev_pull && m_scl) bad_pull = 1'b1;
    prev_pull = sda_pull;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda_low = 0; #T; m_scl = 1; #T; m_sda_low = 1; #T; m_scl = 0; #T;
  endtask

  task automatic bus_stop;
    m_sda_low = 1; #T; m_scl = 1; #T; m_sda_low = 0; #T;
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda_low = ~b[i]; #T; m_scl = 1; #T; m_scl = 0; #T;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    put_bits(b, 8);
    m_sda_low = 0; #T; m_scl = 1; #T; ack = ~sda_line; m_scl = 0; #T;
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] b);
    m_sda_low = 0;
    for (int i = 0; i < 8; i++) begin
      #T; m_scl = 1; #T; b = {b[6:0], sda_line}; m_scl = 0;
    end
    m_sda_low = ack; #T; m_scl = 1; #T; m_scl = 0; #T; m_sda_low = 0;
  endtask

  task automatic set_ptr(input logic [7:0] a, output logic ack);
    logic k1, k2;
    bus_start; put_byte({4'hA, strap, 1'b0}, k1); put_byte(a, k2);
    ack = k1 & k2;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d);
    logic k;
    set_ptr(a, k);
    bus_start; put_byte({4'hA, strap, 1'b1}, k); get_byte(1'b0, d); bus_stop;
  endtask

  task automatic write_at(input logic [7:0] a, input logic [7:0] d, output logic ack);
    logic k, kd;
    set_ptr(a, k); put_byte(d, kd); bus_stop;
    ack = kd;
  endtask

  task automatic t_reset;
    check("R12 sda released after reset", {7'd0, sda_pull}, 8'd0);
    check("R8 checksum valid at reset", {7'd0, checksum_ok}, 8'd1);
  endtask

  task automatic t_defaults;
    logic [7:0] d;
    read_at(8'd0, d);   check("R2 R9 byte 0", d, 8'h80);
    read_at(8'd2, d);   check("R2 R9 byte 2", d, 8'h04);
    read_at(8'd63, d);  check("R9 byte 63", d, 8'hE1);
    read_at(8'd100, d); check("R9 byte 100", d, 8'hFF);
  endtask

  task automatic t_seq;
    logic [7:0] d0, d1, d2, d3; logic k;
    set_ptr(8'd0, k);
    bus_start; put_byte({4'hA, strap, 1'b1}, k);
    get_byte(1'b1, d0); get_byte(1'b1, d1); get_byte(1'b0, d2); bus_stop;
    check("R3 seq byte 0", d0, 8'h80);
    check("R3 seq byte 1", d1, 8'h08);
    check("R3 seq byte 2", d2, 8'h04);
    bus_start; put_byte({4'hA, strap, 1'b1}, k); get_byte(1'b0, d3); bus_stop;
    check("R4 current read continues", d3, 8'h0C);
  endtask

  task automatic t_wrap;
    logic [7:0] a, b; logic k;
    set_ptr(8'd255, k);
    bus_start; put_byte({4'hA, strap, 1'b1}, k);
    get_byte(1'b1, a); get_byte(1'b0, b); bus_stop;
    check("R3 byte 255", a, 8'hFF);
    check("R3 wrap to 0", b, 8'h80);
  endtask

  task automatic t_addr;
    logic k; logic [7:0] d;
    bus_start; put_byte({4'hA, 3'b011, 1'b1}, k); bus_stop;
    check("R1 wrong strap not acked", {7'd0, k}, 8'd0);
    bus_start; put_byte({4'hB, 3'b000, 1'b1}, k); bus_stop;
    check("R1 wrong prefix not acked", {7'd0, k}, 8'd0);
    strap = 3'b101;
    bus_start; put_byte({4'hA, 3'b101, 1'b1}, k); get_byte(1'b0, d); bus_stop;
    check("R1 new strap acked", {7'd0, k}, 8'd1);
  endtask

  task automatic t_user_write;
    logic k0, k1, k2; logic [7:0] d;
    wp = 1;
    set_ptr(8'd200, k0); put_byte(8'hA5, k1); put_byte(8'h3C, k2); bus_stop;
    check("R5 user write acked", {6'd0, k1, k2}, 8'd3);
    read_at(8'd200, d); check("R5 byte 200", d, 8'hA5);
    read_at(8'd201, d); check("R5 byte 201", d, 8'h3C);
  endtask

  task automatic t_protect;
    logic k; logic [7:0] d;
    wp = 1;
    write_at(8'd10, 8'h55, k);
    check("R6 protected write nacked", {7'd0, k}, 8'd0);
    read_at(8'd10, d); check("R6 byte 10 unchanged", d, 8'h00);
    check("R6 checksum still valid", {7'd0, checksum_ok}, 8'd1);
  endtask

  task automatic t_mfr_write;
    logic k; logic [7:0] d;
    wp = 0;
    write_at(8'd10, 8'h11, k);
    check("R7 unlocked write acked", {7'd0, k}, 8'd1);
    check("R8 checksum broken", {7'd0, checksum_ok}, 8'd0);
    read_at(8'd10, d); check("R7 byte 10 stored", d, 8'h11);
    write_at(8'd63, 8'hF2, k);
    check("R8 checksum repaired", {7'd0, checksum_ok}, 8'd1);
    write_at(8'd10, 8'h00, k);
    check("R8 checksum broken again", {7'd0, checksum_ok}, 8'd0);
    write_at(8'd63, 8'hE1, k);
    check("R8 checksum restored", {7'd0, checksum_ok}, 8'd1);
  endtask

  task automatic t_abort;
    logic k; logic [7:0] d;
    wp = 0;
    set_ptr(8'd5, k); put_bits(8'hAA, 4); bus_stop;
    read_at(8'd5, d); check("R10 stop mid-byte no write", d, 8'h01);
    set_ptr(8'd5, k); bus_stop;
    bus_start; put_bits({4'hA, strap, 1'b0}, 3);
    bus_start; put_byte({4'hA, strap, 1'b1}, k); get_byte(1'b0, d); bus_stop;
    check("R10 start mid-byte restarts ack", {7'd0, k}, 8'd1);
    check("R10 R4 read after restart", d, 8'h01);
  endtask

  initial begin
    #52 rst_n = 1;
    #20;
    t_reset;
    t_defaults;
    t_seq;
    t_wrap;
    t_addr;
    t_user_write;
    t_protect;
    t_mfr_write;
    t_abort;
    check("R11 pull only rises with scl low", {7'd0, bad_pull}, 8'd0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #1900000;
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule